// File: doc/BRIEF.md
# Rename Occupancy Tracker

This block keeps count of how many rename registers are in use in each of several register files. The files may overlap, so one architectural destination can be charged to more than one file at once. Every request carries a 32-bit file mask in which each set bit names one file. An allocate takes one mapping in every named file. A release gives one mapping back to each named file. A query returns a failure mask with one bit set for each named file that has no room left.

Each file's capacity is taken from a flat input while reset is held. A capacity of zero marks the file as unbounded, so it never runs out. File 0 stands for the whole physical register space and is charged by every request. Only the occupancy counters and the mask logic are built here. Dependency tracking and value storage belong to other blocks.

Top module: `rename_occupancy_tracker`

## Requirements
- R1: Bit i of every mask selects file i. A query drives `queryResp` bit i high exactly when file i is selected, has a non-zero capacity, and holds as many mappings as that capacity. An all-zero response means every selected file has room. The response is combinational and shows the counts as they stand before the next clock edge.
- R2: File 0 is charged by every allocate and release and is checked by every query, whether or not mask bit 0 is set.
- R3: A file with capacity zero is unbounded. It never sets its response bit and never causes an allocate to be rejected.
- R4: An allocate with `allocValid` high is granted when none of its selected bounded files is full. `allocGrant` is combinational and is low whenever `allocValid` is low. A granted allocate adds one to every selected file at the clock edge.
- R5: An allocate whose selected files include a full bounded file is rejected as a whole. No counter changes, and `errFlag` is high in the following cycle.
- R6: A release with `releaseValid` high subtracts one from every selected file whose count is non-zero.
- R7: A release that selects a file whose count is zero, with no granted allocate to that file in the same cycle, leaves that file's count at zero. `errFlag` is then high in the following cycle. The other selected files are still decremented.
- R8: A granted allocate and a release that select the same file in the same cycle leave that file's count unchanged and do not raise `errFlag`.
- R9: While `rst` is high, each file's capacity is loaded from `capIn`, all counts are cleared and `errFlag` is cleared. Changes on `capIn` after reset has been released have no effect.
- R10: Mask bits at or above NUM_FILES are ignored, and `queryResp` bits at or above NUM_FILES are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; capacities are loaded while it is high |
| capIn | input | NUM_FILES*CNT_W | Capacity of file i in bits [i*CNT_W +: CNT_W]; a value of 0 means unbounded |
| allocValid | input | 1 | Allocate request |
| allocMask | input | 32 | Files charged by the allocate |
| releaseValid | input | 1 | Release request |
| releaseMask | input | 32 | Files credited by the release |
| queryMask | input | 32 | Files checked by the query |
| allocGrant | output | 1 | The allocate in this cycle is accepted |
| queryResp | output | 32 | One bit per selected file that is full |
| errFlag | output | 1 | The previous cycle held a rejected allocate or a release that would underflow |

## Verification
An allocate and a release can arrive in the same cycle. When both select the same file, that file's count must end where it started. When the release finds a count of zero that only the allocate refills, no error may be raised. The bench provokes this by pairing both requests on a partly filled file, on a full file and on an empty file. It then judges the result through the query response of the next cycle and through `errFlag` one cycle after the request. Rejection in the pairing case is also checked: a release still goes ahead when it is paired with an allocate that is refused because another file is full.

// File: rtl/rot_pkg.sv
package rot_pkg;
  localparam int MAX_FILES = 32;

  typedef logic [MAX_FILES-1:0] fileMask_t;

  // strobes from control to the counter datapath
  typedef struct packed {
    fileMask_t incEn;
    fileMask_t decEn;
    logic      errSet;
  } ctrlStrobe_t;
endpackage

// File: rtl/rot_datapath.sv
module rot_datapath
  import rot_pkg::*;
#(
  parameter int NUM_FILES = 4,
  parameter int CNT_W     = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_FILES*CNT_W-1:0] capIn,
  input  ctrlStrobe_t                strobe,
  output fileMask_t                  fullVec,
  output fileMask_t                  emptyVec,
  output logic [NUM_FILES*CNT_W-1:0] usedFlat,
  output logic [NUM_FILES*CNT_W-1:0] capFlat,
  output logic                       errFlag
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  genvar i;
  generate
    for (i = 0; i < MAX_FILES; i++) begin : g_file
      if (i < NUM_FILES) begin : g_live
        logic [CNT_W-1:0] capReg;
        logic [CNT_W-1:0] usedReg;

        always_ff @(posedge clk) begin
          if (rst) begin
            capReg  <= capIn[i*CNT_W +: CNT_W];
            usedReg <= '0;
          end else begin
            unique case ({strobe.incEn[i], strobe.decEn[i]})
              2'b10: if (usedReg != CNT_MAX) usedReg <= usedReg + 1'b1;
              2'b01: if (usedReg != '0) usedReg <= usedReg - 1'b1;
              default: usedReg <= usedReg;
            endcase
          end
        end

        assign fullVec[i]  = (capReg != '0) && (usedReg >= capReg);
        assign emptyVec[i] = (usedReg == '0);
        assign usedFlat[i*CNT_W +: CNT_W] = usedReg;
        assign capFlat[i*CNT_W +: CNT_W]  = capReg;
      end else begin : g_absent
        assign fullVec[i]  = 1'b0;
        assign emptyVec[i] = 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) errFlag <= 1'b0;
    else     errFlag <= strobe.errSet;
  end
endmodule

// File: rtl/rot_ctrl.sv
module rot_ctrl
  import rot_pkg::*;
#(
  parameter int NUM_FILES = 4
) (
  input  logic        allocValid,
  input  fileMask_t   allocMask,
  input  logic        releaseValid,
  input  fileMask_t   releaseMask,
  input  fileMask_t   queryMask,
  input  fileMask_t   fullVec,
  input  fileMask_t   emptyVec,
  output logic        allocGrant,
  output fileMask_t   queryResp,
  output ctrlStrobe_t strobe
);
  localparam logic [MAX_FILES:0] SPAN = (MAX_FILES+1)'(1) << NUM_FILES;
  localparam fileMask_t LIVE = fileMask_t'(SPAN - 1'b1);
  localparam fileMask_t ROOT = fileMask_t'(1);

  fileMask_t allocSel;
  fileMask_t relSel;
  fileMask_t underflow;
  logic      blocked;

  always_comb begin
    allocSel   = (allocMask | ROOT) & LIVE;
    relSel     = releaseValid ? ((releaseMask | ROOT) & LIVE) : '0;
    blocked    = |(allocSel & fullVec);
    allocGrant = allocValid && !blocked;

    strobe.incEn  = allocGrant ? allocSel : '0;
    underflow     = relSel & emptyVec & ~strobe.incEn;
    strobe.decEn  = relSel & ~underflow;
    strobe.errSet = (allocValid && blocked) || (|underflow);

    queryResp = (queryMask | ROOT) & LIVE & fullVec;
  end
endmodule

// File: rtl/rename_occupancy_tracker.sv
module rename_occupancy_tracker
  import rot_pkg::*;
#(
  parameter int NUM_FILES = 4,
  parameter int CNT_W     = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_FILES*CNT_W-1:0] capIn,
  input  logic                       allocValid,
  input  logic [31:0]                allocMask,
  input  logic                       releaseValid,
  input  logic [31:0]                releaseMask,
  input  logic [31:0]                queryMask,
  output logic                       allocGrant,
  output logic [31:0]                queryResp,
  output logic                       errFlag
);
  ctrlStrobe_t                strobe;
  fileMask_t                  fullVec;
  fileMask_t                  emptyVec;
  logic [NUM_FILES*CNT_W-1:0] usedFlat;
  logic [NUM_FILES*CNT_W-1:0] capFlat;

  rot_ctrl #(.NUM_FILES(NUM_FILES)) u_ctrl (
    .allocValid  (allocValid),
    .allocMask   (allocMask),
    .releaseValid(releaseValid),
    .releaseMask (releaseMask),
    .queryMask   (queryMask),
    .fullVec     (fullVec),
    .emptyVec    (emptyVec),
    .allocGrant  (allocGrant),
    .queryResp   (queryResp),
    .strobe      (strobe)
  );

  rot_datapath #(.NUM_FILES(NUM_FILES), .CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .capIn   (capIn),
    .strobe  (strobe),
    .fullVec (fullVec),
    .emptyVec(emptyVec),
    .usedFlat(usedFlat),
    .capFlat (capFlat),
    .errFlag (errFlag)
  );
endmodule

// File: rtl/rot_checker.sv
module rot_checker
  import rot_pkg::*;
#(
  parameter int NUM_FILES = 4,
  parameter int CNT_W     = 6
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       allocValid,
  input logic                       allocGrant,
  input logic [31:0]                queryResp,
  input logic                       errFlag,
  input fileMask_t                  fullVec,
  input logic [NUM_FILES*CNT_W-1:0] usedFlat,
  input logic [NUM_FILES*CNT_W-1:0] capFlat,
  input ctrlStrobe_t                strobe
);
  localparam logic [MAX_FILES:0] SPAN = (MAX_FILES+1)'(1) << NUM_FILES;
  localparam fileMask_t LIVE = fileMask_t'(SPAN - 1'b1);

  p_grant_needs_req_r4: assert property (@(posedge clk) disable iff (rst)
    allocGrant |-> allocValid);

  p_reject_raises_err_r5: assert property (@(posedge clk) disable iff (rst)
    (allocValid && !allocGrant) |=> errFlag);

  p_upper_resp_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (queryResp & ~LIVE) == '0);

  p_reset_clears_r9: assert property (@(posedge clk)
    rst |=> (usedFlat == '0) && !errFlag);

  genvar i;
  generate
    for (i = 0; i < NUM_FILES; i++) begin : g_chk
      p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        (capFlat[i*CNT_W +: CNT_W] != '0) |->
          (usedFlat[i*CNT_W +: CNT_W] <= capFlat[i*CNT_W +: CNT_W]));

      p_unbounded_never_full_r3: assert property (@(posedge clk) disable iff (rst)
        (capFlat[i*CNT_W +: CNT_W] == '0) |-> !fullVec[i]);

      p_empty_stays_r7: assert property (@(posedge clk) disable iff (rst)
        ((usedFlat[i*CNT_W +: CNT_W] == '0) && !strobe.incEn[i]) |=>
          (usedFlat[i*CNT_W +: CNT_W] == '0));

      p_paired_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (strobe.incEn[i] && strobe.decEn[i]) |=>
          $stable(usedFlat[i*CNT_W +: CNT_W]));
    end
  endgenerate
endmodule

bind rename_occupancy_tracker rot_checker #(.NUM_FILES(NUM_FILES), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .allocValid(allocValid),
  .allocGrant(allocGrant),
  .queryResp (queryResp),
  .errFlag   (errFlag),
  .fullVec   (fullVec),
  .usedFlat  (usedFlat),
  .capFlat   (capFlat),
  .strobe    (strobe)
);

// File: tb/tb_rename_occupancy_tracker.sv
module tb_rename_occupancy_tracker;
  localparam int NF = 4;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst;
  logic [NF*CW-1:0] capIn;
  logic          allocValid;
  logic [31:0]   allocMask;
  logic          releaseValid;
  logic [31:0]   releaseMask;
  logic [31:0]   queryMask;
  logic          allocGrant;
  logic [31:0]   queryResp;
  logic          errFlag;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rename_occupancy_tracker #(.NUM_FILES(NF), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .capIn(capIn),
    .allocValid(allocValid), .allocMask(allocMask),
    .releaseValid(releaseValid), .releaseMask(releaseMask),
    .queryMask(queryMask), .allocGrant(allocGrant),
    .queryResp(queryResp), .errFlag(errFlag)
  );

  // {allocValid, allocMask, releaseValid, releaseMask, queryMask, expGrant, expResp, expErrNext}
  // capacities: file0 unbounded, file1 = 2, file2 = 3, file3 = 1
  localparam logic [131:0] VEC [16] = '{
    {1'b0, 32'h0,        1'b0, 32'h0, 32'hE,         1'b0, 32'h0, 1'b0},
    {1'b1, 32'h2,        1'b0, 32'h0, 32'hE,         1'b1, 32'h0, 1'b0},
    {1'b1, 32'hA,        1'b0, 32'h0, 32'hE,         1'b1, 32'h0, 1'b0},
    {1'b0, 32'h0,        1'b0, 32'h0, 32'hE,         1'b0, 32'hA, 1'b0},
    {1'b1, 32'h4,        1'b0, 32'h0, 32'hE,         1'b1, 32'hA, 1'b0},
    {1'b1, 32'h6,        1'b0, 32'h0, 32'h6,         1'b0, 32'h2, 1'b1},
    {1'b0, 32'h0,        1'b1, 32'h8, 32'h8,         1'b0, 32'h8, 1'b0},
    {1'b0, 32'h0,        1'b0, 32'h0, 32'h8,         1'b0, 32'h0, 1'b0},
    {1'b1, 32'h4,        1'b1, 32'h4, 32'h4,         1'b1, 32'h0, 1'b0},
    {1'b0, 32'h0,        1'b1, 32'h4, 32'h4,         1'b0, 32'h0, 1'b0},
    {1'b0, 32'h0,        1'b1, 32'h6, 32'h6,         1'b0, 32'h2, 1'b1},
    {1'b0, 32'h0,        1'b0, 32'h0, 32'h2,         1'b0, 32'h0, 1'b0},
    {1'b1, 32'h2,        1'b0, 32'h0, 32'h2,         1'b1, 32'h0, 1'b0},
    {1'b0, 32'h0,        1'b0, 32'h0, 32'hFFFF0002,  1'b0, 32'h2, 1'b0},
    {1'b1, 32'h80000004, 1'b0, 32'h0, 32'h4,         1'b1, 32'h0, 1'b0},
    {1'b0, 32'h0,        1'b0, 32'h0, 32'h4,         1'b0, 32'h0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic av, input logic [31:0] am, input logic rv,
                       input logic [31:0] rm, input logic [31:0] qm);
    allocValid = av; allocMask = am; releaseValid = rv; releaseMask = rm; queryMask = qm;
  endtask

  task automatic doReset(input logic [NF*CW-1:0] caps);
    @(negedge clk);
    capIn = caps;
    rst = 1'b1;
    drive(1'b0, 32'h0, 1'b0, 32'h0, 32'h0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic prevErr;
    rst = 1'b1;
    capIn = '0;
    drive(1'b0, 32'h0, 1'b0, 32'h0, 32'h0);

    // reset state, R9
    doReset({6'd1, 6'd3, 6'd2, 6'd0});
    drive(1'b0, 32'h0, 1'b0, 32'h0, 32'hFFFFFFFF);
    #1;
    check("R9 reset errFlag", {31'b0, errFlag}, 32'h0);
    check("R9 reset queryResp empty", queryResp, 32'h0);
    check("R4 no grant without request", {31'b0, allocGrant}, 32'h0);

    // vector table covers R1 R3 R4 R5 R6 R7 R8 R10
    prevErr = 1'b0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      check($sformatf("R5/R7 errFlag before step %0d", k), {31'b0, errFlag}, {31'b0, prevErr});
      drive(VEC[k][131], VEC[k][130:99], VEC[k][98], VEC[k][97:66], VEC[k][65:34]);
      #1;
      check($sformatf("R4/R5 allocGrant step %0d", k), {31'b0, allocGrant}, {31'b0, VEC[k][33]});
      check($sformatf("R1/R3/R10 queryResp step %0d", k), queryResp, VEC[k][32:1]);
      prevErr = VEC[k][0];
    end
    @(negedge clk);
    check("R5/R7 errFlag after table", {31'b0, errFlag}, {31'b0, prevErr});

    // file 0 forced into every mask, capacity latched at reset: R2 R9
    doReset({6'd0, 6'd0, 6'd0, 6'd1});
    capIn = '0;                                 // must have no effect (R9)
    drive(1'b1, 32'h0, 1'b0, 32'h0, 32'h0);
    #1;
    check("R2 empty mask allocate granted", {31'b0, allocGrant}, 32'h1);
    @(negedge clk);
    drive(1'b1, 32'h2, 1'b0, 32'h0, 32'h0);
    #1;
    check("R2 query of empty mask sees file 0 full", queryResp, 32'h1);
    check("R2/R9 allocate refused by file 0", {31'b0, allocGrant}, 32'h0);
    @(negedge clk);
    check("R5 errFlag after refusal", {31'b0, errFlag}, 32'h1);
    // refused allocate paired with release: release proceeds (R8 pairing)
    drive(1'b1, 32'h2, 1'b1, 32'h0, 32'h0);
    #1;
    check("R5 paired allocate still refused", {31'b0, allocGrant}, 32'h0);
    @(negedge clk);
    drive(1'b0, 32'h0, 1'b0, 32'h0, 32'h0);
    #1;
    check("R6 file 0 released by empty mask", queryResp, 32'h0);
    check("R5 errFlag after paired refusal", {31'b0, errFlag}, 32'h1);
    // empty file: allocate and release paired -> no error, count unchanged (R8)
    @(negedge clk);
    drive(1'b1, 32'h0, 1'b1, 32'h0, 32'h0);
    #1;
    check("R8 paired on empty file granted", {31'b0, allocGrant}, 32'h1);
    @(negedge clk);
    drive(1'b0, 32'h0, 1'b1, 32'h0, 32'h0);
    #1;
    check("R8 no error on paired empty file", {31'b0, errFlag}, 32'h0);
    check("R8 count unchanged at zero", queryResp, 32'h0);
    @(negedge clk);
    drive(1'b0, 32'h0, 1'b0, 32'h0, 32'h0);
    #1;
    check("R7 underflow on file 0 raises errFlag", {31'b0, errFlag}, 32'h1);
    check("R7 count held at zero", queryResp, 32'h0);

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule